// File: doc/BRIEF.md
# Data EEPROM Erase/Program Sequencer

This block runs the erase and program cycles of a small on-chip data EEPROM, with the storage held as a register file inside the block. Software reaches it through a narrow register port with four selectable locations: a 16-bit control word, a target address, a data word, and a read window onto the stored word at the target address. Software first writes the arm bit and the operation fields. A second control write then raises the start bit, and the block runs a timed sequence of erase and program phases set by cycle-count parameters.

An erase clears one word, an aligned group of four or eight words, or the whole array. A one-word write can erase its target first, or it can program over the stored value with no erase, which can only turn ones into zeros. When a sequence ends, the block clears its own start and arm bits. A synchronous abort input stops any sequence in progress and leaves a sticky fault flag. An opcode that is undefined, or that disagrees with the erase-select bit, ends at once and leaves the array unchanged.

Top module: `eeprom_sequencer`

## Requirements
- R1: Software can set the start bit (control bit 15) but cannot clear it. Once set, it stays 1 until its sequence completes or is aborted, and the `busy` output always equals it.
- R2: A control write with bit 15 set raises start only if the arm bit (control bit 14) already held 1 before that write. Otherwise start stays 0 and nothing runs.
- R3: When a sequence completes normally, hardware clears start and arm in the same cycle and leaves the fault bit unchanged.
- R4: With erase-select (control bit 6) at 1, opcode 6'b011000 erases only the addressed word to 16'hFFFF, and `busy` stays high for ERASE_CYC+1 cycles.
- R5: Opcode 6'b011001 erases the four words whose address matches the target with bits [1:0] ignored. Opcode 6'b011010 erases the eight words that match with bits [2:0] ignored. Words outside the group keep their values.
- R6: Any opcode of the form 6'b0100xx with erase-select at 1 erases every word of the array.
- R7: With erase-select at 0 and prog-only (control bit 12) at 0, an opcode 6'b0001xx erases the target and then programs it. The word then reads back as the data register, and `busy` stays high for ERASE_CYC+PROG_CYC+1 cycles.
- R8: With prog-only at 1, the write skips the erase. The stored word becomes its old value ANDed with the data register, and `busy` stays high for PROG_CYC+1 cycles.
- R9: An undefined opcode, or an opcode that does not match erase-select, holds `busy` for exactly one cycle, clears start and arm, and leaves the array unchanged.
- R10: An abort while `busy` is high clears start and arm on the next edge, sets the fault bit (control bit 13) and leaves the array unchanged, even on the sequence's last cycle. An abort while idle has no effect.
- R11: The fault bit is sticky. Only a control write that carries bit 13 at 0 clears it; normal completion does not.
- R12: While `busy` is high, bus writes to the control, address and data locations have no effect.
- R13: `bus_sel` picks the readback: 0 gives the control word, with bits 11:7 reading 0 and the opcode in bits 5:0; 1 gives the address; 2 gives the data register; 3 gives the stored word at the address register. Writes to location 3 have no effect. After reset all registers read 0 and every word reads 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| abort_req | input | 1 | Synchronous abort of a sequence in progress |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select: 0 control, 1 address, 2 data, 3 array window |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Readback of the selected location |
| busy | output | 1 | High while the start bit is set |

## Verification
Two functions can fall in the same cycle: an abort can arrive on the final cycle of a sequence, the cycle in which the erase or program result would be committed. The bench counts cycles from the start write so that the abort lands on exactly that edge. It then requires that the array word keeps its old value, that the fault bit is set, and that start and arm are both clear. A second case is a bus write issued while a sequence is finishing: it must be dropped. A reference model stepped on every clock confirms both outcomes cycle by cycle.

// File: rtl/eepc_pkg.sv
// Shared types and constants of the data EEPROM sequencer.
// Assumes a 16-bit control word whose bit positions are fixed.
package eepc_pkg;

    // Decoded meaning of the opcode together with the erase-select bit.
    typedef enum logic [2:0] {
        OPK_BAD,
        OPK_ERA1,
        OPK_ERA4,
        OPK_ERA8,
        OPK_ERAALL,
        OPK_WRITE
    } opk_t;

    // Sequencer phase.
    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ERASE,
        SQ_PROG
    } sq_t;

    // Control word bit positions.
    localparam int CB_START   = 15;
    localparam int CB_ARM     = 14;
    localparam int CB_FAULT   = 13;
    localparam int CB_NOERASE = 12;
    localparam int CB_ERSEL   = 6;
    localparam int OP_W       = 6;

    // Register select codes.
    localparam logic [1:0] RS_CTL   = 2'd0;
    localparam logic [1:0] RS_ADDR  = 2'd1;
    localparam logic [1:0] RS_DATA  = 2'd2;
    localparam logic [1:0] RS_ARRAY = 2'd3;

endpackage

// File: rtl/eepc_opdec.sv
// Opcode decoder: turns the opcode and the erase-select bit into an
// operation kind. Purely combinational. Any code that is undefined, or that
// disagrees with erase-select, yields OPK_BAD.
module eepc_opdec
    import eepc_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic            erase_sel,
    output opk_t            kind
);

    // Decode the operation kind.
    always_comb begin
        kind = OPK_BAD;
        if (erase_sel) begin
            if (op[5:2] == 4'b0100)      kind = OPK_ERAALL;
            else if (op == 6'b011000)    kind = OPK_ERA1;
            else if (op == 6'b011001)    kind = OPK_ERA4;
            else if (op == 6'b011010)    kind = OPK_ERA8;
        end else if (op[5:2] == 4'b0001) begin
            kind = OPK_WRITE;
        end
    end

endmodule

// File: rtl/eepc_phase_timer.sv
// Down-counter that times one erase or program phase. A load sets the count
// to the phase length minus one. While running it counts down to zero and
// then holds there; done is high at zero. Assumes the load value fits CW bits.
module eepc_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    // Load or decrement the phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (load)                  cnt_q <= load_val;
        else if (run && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/eepc_word_array.sv
// Register-file model of the EEPROM array. An erase sets every word whose
// masked address matches the masked base to all ones. A program ANDs data
// into one word. Erase wins if both apply to the same word. Reset fills the
// array with ones. Assumes WORDS == 2**AW.
module eepc_word_array #(
    parameter int WORDS = 32,
    parameter int DW    = 16,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          erase_en,
    input  logic [AW-1:0] erase_base,
    input  logic [AW-1:0] erase_mask,
    input  logic          prog_en,
    input  logic [AW-1:0] prog_addr,
    input  logic [DW-1:0] prog_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] words [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        localparam logic [AW-1:0] IDX = AW'(i);
        logic [DW-1:0] word_q;
        logic          hit_e;
        logic          hit_p;

        assign hit_e = erase_en && ((IDX & erase_mask) == (erase_base & erase_mask));
        assign hit_p = prog_en && (prog_addr == IDX);

        // Update one stored word on erase or program.
        always_ff @(posedge clk) begin
            if (!rst_n)     word_q <= '1;
            else if (hit_e) word_q <= '1;
            else if (hit_p) word_q <= word_q & prog_data;
        end

        assign words[i] = word_q;
    end

    assign rd_data = words[rd_addr];

endmodule

// File: rtl/eeprom_sequencer.sv
// Top of the data EEPROM sequencer. Holds the control, address and data
// registers, runs the erase/program phase machine, and handles the abort
// input. Bus writes are dropped while start is set. Assumes WORDS is a power
// of two, at least 8, and no larger than 2**16. ERASE_CYC and PROG_CYC must
// each be at least 1.
module eeprom_sequencer
    import eepc_pkg::*;
#(
    parameter int WORDS     = 32,
    parameter int DW        = 16,
    parameter int ERASE_CYC = 6,
    parameter int PROG_CYC  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        abort_req,
    input  logic        bus_we,
    input  logic [1:0]  bus_sel,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        busy
);

    localparam int AW   = $clog2(WORDS);
    localparam int TMAX = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int TCW  = $clog2(TMAX + 1);

    logic            start_q, arm_q, fault_q, noer_q, ersel_q;
    logic [OP_W-1:0] op_q;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   data_q;
    sq_t             st_q;

    opk_t            kind;
    logic            tdone, tload;
    logic [TCW-1:0]  tval;
    logic            erase_en, prog_en;
    logic [AW-1:0]   erase_mask;
    logic [DW-1:0]   word_rd;
    logic            abort_hit, reg_wr;
    logic            unused_wbits;

    assign abort_hit    = abort_req && start_q;
    assign reg_wr       = bus_we && !start_q;
    assign busy         = start_q;
    assign unused_wbits = ^bus_wdata[11:7];

    eepc_opdec u_dec (
        .op        (op_q),
        .erase_sel (ersel_q),
        .kind      (kind)
    );

    eepc_phase_timer #(.CW(TCW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tload),
        .load_val (tval),
        .run      (st_q != SQ_IDLE),
        .done     (tdone)
    );

    eepc_word_array #(.WORDS(WORDS), .DW(DW), .AW(AW)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .erase_en   (erase_en),
        .erase_base (addr_q),
        .erase_mask (erase_mask),
        .prog_en    (prog_en),
        .prog_addr  (addr_q),
        .prog_data  (data_q),
        .rd_addr    (addr_q),
        .rd_data    (word_rd)
    );

    // Choose when to load the phase timer and with which length.
    always_comb begin
        tload = 1'b0;
        tval  = TCW'(ERASE_CYC - 1);
        if (!abort_hit) begin
            if (st_q == SQ_IDLE && start_q && kind != OPK_BAD) begin
                tload = 1'b1;
                if (kind == OPK_WRITE && noer_q) tval = TCW'(PROG_CYC - 1);
            end else if (st_q == SQ_ERASE && tdone && kind == OPK_WRITE) begin
                tload = 1'b1;
                tval  = TCW'(PROG_CYC - 1);
            end
        end
    end

    // Commit strobes to the array at the end of each phase.
    always_comb begin
        erase_en = (st_q == SQ_ERASE) && tdone && !abort_hit;
        prog_en  = (st_q == SQ_PROG)  && tdone && !abort_hit;
    end

    // Address mask of the erase group: one word, four, eight or all.
    always_comb begin
        unique case (kind)
            OPK_ERA4:   erase_mask = ~AW'(3);
            OPK_ERA8:   erase_mask = ~AW'(7);
            OPK_ERAALL: erase_mask = '0;
            default:    erase_mask = '1;
        endcase
    end

    // Control register and phase machine; abort has top priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            arm_q   <= 1'b0;
            fault_q <= 1'b0;
            noer_q  <= 1'b0;
            ersel_q <= 1'b0;
            op_q    <= '0;
            st_q    <= SQ_IDLE;
        end else if (abort_hit) begin
            start_q <= 1'b0;
            arm_q   <= 1'b0;
            fault_q <= 1'b1;
            st_q    <= SQ_IDLE;
        end else begin
            unique case (st_q)
                SQ_IDLE: begin
                    if (start_q) begin
                        if (kind == OPK_BAD) begin
                            start_q <= 1'b0;
                            arm_q   <= 1'b0;
                        end else if (kind == OPK_WRITE && noer_q) begin
                            st_q <= SQ_PROG;
                        end else begin
                            st_q <= SQ_ERASE;
                        end
                    end else if (reg_wr && bus_sel == RS_CTL) begin
                        start_q <= bus_wdata[CB_START] & arm_q;
                        arm_q   <= bus_wdata[CB_ARM];
                        fault_q <= bus_wdata[CB_FAULT];
                        noer_q  <= bus_wdata[CB_NOERASE];
                        ersel_q <= bus_wdata[CB_ERSEL];
                        op_q    <= bus_wdata[OP_W-1:0];
                    end
                end
                SQ_ERASE: begin
                    if (tdone) begin
                        if (kind == OPK_WRITE) begin
                            st_q <= SQ_PROG;
                        end else begin
                            st_q    <= SQ_IDLE;
                            start_q <= 1'b0;
                            arm_q   <= 1'b0;
                        end
                    end
                end
                SQ_PROG: begin
                    if (tdone) begin
                        st_q    <= SQ_IDLE;
                        start_q <= 1'b0;
                        arm_q   <= 1'b0;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    // Address and data registers, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (reg_wr && bus_sel == RS_ADDR) begin
            addr_q <= bus_wdata[AW-1:0];
        end else if (reg_wr && bus_sel == RS_DATA) begin
            data_q <= bus_wdata[DW-1:0];
        end
    end

    // Readback multiplexer.
    always_comb begin
        unique case (bus_sel)
            RS_CTL:   bus_rdata = {start_q, arm_q, fault_q, noer_q, 5'b0, ersel_q, op_q};
            RS_ADDR:  bus_rdata = 16'(addr_q);
            RS_DATA:  bus_rdata = 16'(data_q);
            default:  bus_rdata = 16'(word_rd);
        endcase
    end

endmodule

// File: rtl/eeprom_sequencer_chk.sv
// Assertion checker bound into eeprom_sequencer. It watches the ports and a
// few internal registers to check the start, arm, fault and write-ignore rules.
module eeprom_sequencer_chk
    import eepc_pkg::*;
#(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          abort_req,
    input logic          bus_we,
    input logic [1:0]    bus_sel,
    input logic [15:0]   bus_wdata,
    input logic          busy,
    input logic          arm_q,
    input logic          fault_q,
    input logic [AW-1:0] addr_q,
    input sq_t           st_q,
    input logic          tdone
);

    // R1: a running phase that has not ended keeps start set.
    assert_start_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q != SQ_IDLE && !tdone && !abort_req) |=> busy);

    // R1: a non-idle phase implies the start bit is set.
    assert_phase_needs_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != SQ_IDLE) |-> busy);

    // R2: a start write without a prior arm does nothing.
    assert_start_needs_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_we && bus_sel == RS_CTL && bus_wdata[CB_START] && !arm_q) |=> !busy);

    // R3: whenever start falls, arm is already clear.
    assert_end_clears_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !arm_q);

    // R10: abort while busy clears start and arm and sets fault.
    assert_abort_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort_req) |=> (!busy && fault_q && !arm_q));

    // R11: fault never clears without a control write.
    assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !(bus_we && bus_sel == RS_CTL)) |=> fault_q);

    // R12: an address write while busy is dropped.
    assert_addr_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_we && bus_sel == RS_ADDR) |=> $stable(addr_q));

endmodule

bind eeprom_sequencer eeprom_sequencer_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort_req (abort_req),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .arm_q     (arm_q),
    .fault_q   (fault_q),
    .addr_q    (addr_q),
    .st_q      (st_q),
    .tdone     (tdone)
);

// File: tb/sim_eeprom_sequencer.sv
// Bench for eeprom_sequencer. A behavioural model is stepped on every rising
// edge and compared with busy and the readback after every falling edge.
// Directed checks compare against hand-worked values.
module sim_eeprom_sequencer;

    localparam int WORDS = 32;
    localparam int E     = 6;
    localparam int P     = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        abort_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    wire  [15:0] bus_rdata;
    wire         busy;

    always #5 clk = ~clk;

    eeprom_sequencer #(.WORDS(WORDS), .DW(16), .ERASE_CYC(E), .PROG_CYC(P)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort_req (abort_req),
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy)
    );

    // Reference model state.
    bit        m_start, m_arm, m_fault, m_noer, m_esel;
    bit [5:0]  m_op;
    int        m_addr;
    bit [15:0] m_data;
    bit [15:0] m_mem [WORDS];
    int        m_phase;   // 0 idle, 1 erase, 2 program
    int        m_left;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    fin = 1'b0;
    string tag = "R13";

    // Operation kind: 0 bad, 1 one word, 2 four, 3 eight, 4 all, 5 write.
    function automatic int kind_of(bit [5:0] op, bit esel);
        if (!esel) return (op >= 6'd4 && op <= 6'd7) ? 5 : 0;
        if (op == 6'd24) return 1;
        if (op == 6'd25) return 2;
        if (op == 6'd26) return 3;
        if (op >= 6'd16 && op <= 6'd19) return 4;
        return 0;
    endfunction

    function automatic bit [15:0] m_rd(logic [1:0] sel);
        case (sel)
            2'd0: return {m_start, m_arm, m_fault, m_noer, 5'd0, m_esel, m_op};
            2'd1: return 16'(m_addr);
            2'd2: return m_data;
            default: return m_mem[m_addr];
        endcase
    endfunction

    function automatic void m_erase(int k);
        for (int i = 0; i < WORDS; i++) begin
            if (k == 4 || (k == 3 && i / 8 == m_addr / 8) ||
                (k == 2 && i / 4 == m_addr / 4) ||
                ((k == 1 || k == 5) && i == m_addr))
                m_mem[i] = 16'hFFFF;
        end
    endfunction

    // Step the reference model on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_start = 0; m_arm = 0; m_fault = 0; m_noer = 0; m_esel = 0;
            m_op = 0; m_addr = 0; m_data = 0; m_phase = 0; m_left = 0;
            for (int i = 0; i < WORDS; i++) m_mem[i] = 16'hFFFF;
        end else if (abort_req && m_start) begin
            m_start = 0; m_arm = 0; m_fault = 1; m_phase = 0;
        end else if (m_phase == 0) begin
            if (m_start) begin
                int k;
                k = kind_of(m_op, m_esel);
                if (k == 0) begin
                    m_start = 0; m_arm = 0;
                end else if (k == 5 && m_noer) begin
                    m_phase = 2; m_left = P;
                end else begin
                    m_phase = 1; m_left = E;
                end
            end else if (bus_we) begin
                case (bus_sel)
                    2'd0: begin
                        m_start = bus_wdata[15] & m_arm;
                        m_arm   = bus_wdata[14];
                        m_fault = bus_wdata[13];
                        m_noer  = bus_wdata[12];
                        m_esel  = bus_wdata[6];
                        m_op    = bus_wdata[5:0];
                    end
                    2'd1: m_addr = int'(bus_wdata) % WORDS;
                    2'd2: m_data = bus_wdata;
                    default: ;
                endcase
            end
        end else begin
            m_left = m_left - 1;
            if (m_left == 0) begin
                if (m_phase == 1) begin
                    m_erase(kind_of(m_op, m_esel));
                    if (kind_of(m_op, m_esel) == 5) begin
                        m_phase = 2; m_left = P;
                    end else begin
                        m_phase = 0; m_start = 0; m_arm = 0;
                    end
                end else begin
                    m_mem[m_addr] = m_mem[m_addr] & m_data;
                    m_phase = 0; m_start = 0; m_arm = 0;
                end
            end
        end
    end

    task automatic check(string req, logic [15:0] act, logic [15:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One cycle: drive inputs after the falling edge, then compare with the model.
    task automatic tick(logic we, logic [1:0] sel, logic [15:0] wd, logic ab);
        @(negedge clk);
        bus_we = we; bus_sel = sel; bus_wdata = wd; abort_req = ab;
        #1;
        check(tag, 16'(busy), 16'(m_start), "busy vs model");
        check(tag, bus_rdata, m_rd(sel), "readback vs model");
    endtask

    task automatic wr(logic [1:0] sel, logic [15:0] d);
        tick(1'b1, sel, d, 1'b0);
    endtask

    task automatic peek(logic [1:0] sel, logic [15:0] exp, string req);
        tick(1'b0, sel, 16'd0, 1'b0);
        check(req, bus_rdata, exp, "readback");
    endtask

    function automatic logic [15:0] ctl(bit st, bit arm, bit flt, bit noer, bit esel, bit [5:0] op);
        return {st, arm, flt, noer, 5'd0, esel, op};
    endfunction

    task automatic start_op(bit noer, bit esel, bit [5:0] op, bit flt);
        wr(2'd0, ctl(0, 1, flt, noer, esel, op));
        wr(2'd0, ctl(1, 1, flt, noer, esel, op));
    endtask

    // Count cycles that busy stays high after a start write.
    task automatic measure(output int n);
        n = 0;
        do begin
            tick(1'b0, 2'd0, 16'd0, 1'b0);
            if (busy) n++;
        end while (busy && n < 200);
    endtask

    task automatic put_word(int a, logic [15:0] d);
        int n;
        wr(2'd1, 16'(a));
        wr(2'd2, d);
        start_op(0, 0, 6'b000100, 0);
        measure(n);
    endtask

    task automatic read_word(int a, logic [15:0] exp, string req);
        wr(2'd1, 16'(a));
        peek(2'd3, exp, req);
    endtask

    initial begin
        int n;
        // R13 reset state
        tag = "R13";
        repeat (3) tick(1'b0, 2'd0, 16'd0, 1'b0);
        rst_n = 1'b1;
        peek(2'd0, 16'h0000, "R13");
        peek(2'd3, 16'hFFFF, "R13");
        wr(2'd3, 16'h0000);
        peek(2'd3, 16'hFFFF, "R13");

        // R2 start without arm
        tag = "R2";
        wr(2'd0, ctl(1, 0, 0, 0, 0, 6'b000100));
        peek(2'd0, 16'h0004, "R2");
        check("R2", 16'(busy), 16'd0, "busy after unarmed start");

        // R7 write with erase first
        tag = "R7";
        wr(2'd1, 16'd3);
        wr(2'd2, 16'h1234);
        start_op(0, 0, 6'b000100, 0);
        measure(n);
        check("R7", 16'(n), 16'(E + P + 1), "busy cycles erase+program");
        peek(2'd0, 16'h0004, "R3");
        peek(2'd3, 16'h1234, "R7");

        // R8 program only
        tag = "R8";
        wr(2'd2, 16'hFF0F);
        start_op(1, 0, 6'b000111, 0);
        measure(n);
        check("R8", 16'(n), 16'(P + 1), "busy cycles program only");
        peek(2'd3, 16'h1204, "R8");
        peek(2'd0, 16'h1007, "R3");

        // R12 and R1 writes dropped while busy
        tag = "R12";
        wr(2'd2, 16'hAAAA);
        start_op(0, 0, 6'b000101, 0);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'd9);
        wr(2'd2, 16'h0000);
        check("R1", 16'(busy), 16'd1, "start survives software clear");
        measure(n);
        check("R12", 16'(n), 16'(E + P + 1 - 3), "remaining busy cycles");
        peek(2'd1, 16'd3, "R12");
        peek(2'd2, 16'hAAAA, "R12");
        peek(2'd3, 16'hAAAA, "R1");

        // R5 four-word aligned erase
        tag = "R5";
        put_word(4, 16'h0404);
        put_word(7, 16'h0707);
        put_word(8, 16'h0808);
        wr(2'd1, 16'd6);
        start_op(0, 1, 6'b011001, 0);
        measure(n);
        check("R5", 16'(n), 16'(E + 1), "busy cycles four-word erase");
        read_word(4, 16'hFFFF, "R5");
        read_word(7, 16'hFFFF, "R5");
        read_word(3, 16'hAAAA, "R5");
        read_word(8, 16'h0808, "R5");

        // R5 eight-word aligned erase
        put_word(7, 16'h0707);
        put_word(15, 16'h0F0F);
        put_word(16, 16'h1010);
        wr(2'd1, 16'd13);
        start_op(0, 1, 6'b011010, 0);
        measure(n);
        read_word(8, 16'hFFFF, "R5");
        read_word(15, 16'hFFFF, "R5");
        read_word(7, 16'h0707, "R5");
        read_word(16, 16'h1010, "R5");

        // R4 single-word erase
        tag = "R4";
        wr(2'd1, 16'd16);
        start_op(0, 1, 6'b011000, 0);
        measure(n);
        check("R4", 16'(n), 16'(E + 1), "busy cycles one-word erase");
        peek(2'd3, 16'hFFFF, "R4");
        read_word(7, 16'h0707, "R4");

        // R9 undefined and mismatched opcodes
        tag = "R9";
        wr(2'd1, 16'd3);
        start_op(0, 1, 6'b011011, 0);
        measure(n);
        check("R9", 16'(n), 16'd1, "busy cycles undefined opcode");
        peek(2'd0, 16'h005B, "R9");
        start_op(0, 1, 6'b000100, 0);
        measure(n);
        check("R9", 16'(n), 16'd1, "busy cycles mismatched opcode");
        peek(2'd3, 16'hAAAA, "R9");

        // R10 abort mid-erase
        tag = "R10";
        wr(2'd2, 16'h0000);
        start_op(0, 0, 6'b000100, 0);
        repeat (3) tick(1'b0, 2'd0, 16'd0, 1'b0);
        tick(1'b0, 2'd0, 16'd0, 1'b1);
        peek(2'd0, 16'h2004, "R10");
        peek(2'd3, 16'hAAAA, "R10");

        // R11 fault survives a successful operation
        tag = "R11";
        start_op(1, 0, 6'b000100, 1);
        wr(2'd0, 16'h0000);
        measure(n);
        peek(2'd0, 16'h3004, "R11");
        peek(2'd3, 16'h0000, "R11");
        wr(2'd0, 16'h0000);
        peek(2'd0, 16'h0000, "R11");

        // R10 abort on the final cycle of a program-only write
        tag = "R10";
        put_word(3, 16'h5555);
        wr(2'd2, 16'h0000);
        start_op(1, 0, 6'b000100, 0);
        repeat (P) tick(1'b0, 2'd0, 16'd0, 1'b0);
        tick(1'b0, 2'd0, 16'd0, 1'b1);
        peek(2'd0, 16'h3004, "R10");
        peek(2'd3, 16'h5555, "R10");

        // R10 abort while idle has no effect
        wr(2'd0, 16'h0000);
        tick(1'b0, 2'd0, 16'd0, 1'b1);
        peek(2'd0, 16'h0000, "R10");

        // R6 whole-array erase
        tag = "R6";
        start_op(0, 1, 6'b010010, 0);
        measure(n);
        check("R6", 16'(n), 16'(E + 1), "busy cycles full erase");
        read_word(3, 16'hFFFF, "R6");
        read_word(7, 16'hFFFF, "R6");
        read_word(16, 16'hFFFF, "R6");

        fin = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1_000_000;
        if (!fin) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule